// File: doc/BRIEF.md
# JTAG Scan Command Sequencer

This block is a hardware engine that drives a JTAG chain from a master port. It accepts one high-level command at a time and expands it into the TCK, TMS and TDI waveforms that walk the target TAP controllers along the correct path. Four commands exist: an instruction-register scan, a data-register scan, a data-register scan that also compares the returned TDO bits against an expected pattern, and a timed stay in Run-Test/Idle. Every command starts and ends in Run-Test/Idle, so commands can be issued back to back with no bookkeeping by the caller.

The caller presents a command code, a bit length, up to 64 bits of shift data (LSB shifted first) and, for compare scans, the expected TDO pattern, then pulses `start`. While the engine works, `busy` is high. When the command completes, `done` pulses for one cycle, `captureOut` holds the TDO bits seen during a data scan, and `mismatch` reports the compare result. TCK is derived from the system clock: each half period lasts `HALF_CYC` clock cycles, so with a 50 MHz clock the default of 3 gives a 120 ns TCK period, above the 100 ns minimum and with both halves above 50 ns. Right after reset the engine parks the chain by itself: it forces every target into Test-Logic-Reset and then steps into Run-Test/Idle.

Top module: `jscan_seq`

## Requirements
- R1: After reset, with `busy` high and no `done`, the engine issues six TCK pulses: five with TMS=1 (reaching Test-Logic-Reset from any TAP state) and then one with TMS=0, leaving the chain in Run-Test/Idle.
- R2: Command code 0 is an instruction scan, whose entry pulses carry TMS 1,1,0,0; codes 1 and 2 are data scans, whose entry pulses carry TMS 1,0,0. An instruction scan therefore takes 6+N TCK pulses and a data scan 5+N, where N is the effective length.
- R3: During shifting, bit i of `shiftIn` is driven on TDI for the i-th shift pulse, starting with bit 0; only the final shift pulse has TMS=1. A length of 0 acts as 1 and a length above 64 acts as 64.
- R4: After the shift, one TMS=1 pulse (Update) and one TMS=0 pulse bring the chain back to Run-Test/Idle; whenever `busy` is low, TCK and TMS are both low.
- R5: On a data scan, bit i of `captureOut` is the TDO value at the rising TCK edge of the i-th shift pulse, bits at or above the length read 0; the start of any command clears `captureOut` and `mismatch`, so after an instruction scan or a wait `captureOut` is 0.
- R6: Only code 2 sets `mismatch`, in the same cycle as `done`, and only when some captured bit below the length differs from the same bit of `expectIn`; differences at or above the length are ignored.
- R7: Code 3 holds TMS=0 for exactly `waitCnt` TCK pulses; a count of 0 completes with no pulse at all.
- R8: TCK high and low phases each last `HALF_CYC` clock cycles while a command runs (the low phase may stretch between commands); TMS and TDI change only while TCK is low, and TDO is sampled at the rising edge.
- R9: `start` is taken only while `busy` is low; a start while busy has no effect. `done` is a single-cycle pulse that appears with `busy` already low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request, taken when `busy` is low |
| cmd | input | 2 | Command code: 0 IR scan, 1 DR scan, 2 DR scan with compare, 3 wait |
| bitLen | input | 16 | Scan length in bits |
| waitCnt | input | 16 | Wait length in TCK periods |
| shiftIn | input | 64 | Data shifted out on TDI, bit 0 first |
| expectIn | input | 64 | Expected TDO pattern for compare scans |
| tdo | input | 1 | Serial data returned by the chain |
| busy | output | 1 | Engine active (boot sequence or command) |
| done | output | 1 | One-cycle completion pulse |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG serial data to the chain |
| captureOut | output | 64 | TDO bits captured by the last data scan |
| mismatch | output | 1 | Compare result of the last compare scan |

## Verification
A wrong state or segment counter shows up as a TMS pattern that walks the target TAP off the intended path, so a port-level TAP model in the bench ends in a state other than Run-Test/Idle or counts the wrong number of shifted bits; the error is visible at the very next `done`. An off-by-one in the bit index shifts the TDI log and the captured TDO word by one position, which the per-command comparison of both words exposes on the first scan with a non-symmetric pattern. A faulty TCK divider or a TMS update in the wrong phase shows within one TCK period as a high phase of the wrong width or a TMS edge while TCK is high.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

  // Width of the shift, expect and capture words.
  parameter int DATA_W = 64;
  localparam int IDX_W = $clog2(DATA_W);

  typedef enum logic [1:0] {
    CMD_IR    = 2'd0,
    CMD_DR    = 2'd1,
    CMD_DRCMP = 2'd2,
    CMD_WAIT  = 2'd3
  } cmd_e;

  // Strobes from the sequencing control to the pin datapath.
  typedef struct packed {
    logic             run;      // TCK pulses are being produced
    logic             load;     // latch operands, clear results
    logic             tmsBit;   // TMS value for the current pulse
    logic             shiftEn;  // current pulse shifts a data bit
    logic             capEn;    // sample TDO at this pulse's rise
    logic             finish;   // command completes this cycle
    logic             cmpEn;    // command compares captured data
    logic [IDX_W-1:0] bitIdx;   // bit position of the current pulse
  } strobe_t;

endpackage

// File: rtl/jscan_ctrl.sv
module jscan_ctrl
  import jscan_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        cmd,
  input  logic [LEN_W-1:0]  bitLen,
  input  logic [WAIT_W-1:0] waitCnt,
  input  logic              pulseEnd,
  output strobe_t           st,
  output logic              busy,
  output logic              done
);

  localparam int CNT_W = (LEN_W > WAIT_W) ? LEN_W : WAIT_W;
  localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(DATA_W);
  localparam logic [CNT_W-1:0] BOOT_LAST = CNT_W'(5);
  localparam logic [CNT_W-1:0] IR_HEAD_LAST = CNT_W'(3);
  localparam logic [CNT_W-1:0] DR_HEAD_LAST = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [2:0] {
    S_BOOT, S_IDLE, S_HEAD, S_SHIFT, S_TAIL, S_WAIT
  } state_e;

  state_e            state, nextSeg;
  cmd_e              cmdReg;
  logic [CNT_W-1:0]  cnt, lenReg, waitReg;
  logic [LEN_W-1:0]  lenClamp;
  logic              lastPulse;
  logic              isIr;

  assign isIr = (cmdReg == CMD_IR);
  assign busy = (state != S_IDLE);

  always_comb begin
    if (bitLen == '0)          lenClamp = LEN_W'(1);
    else if (bitLen > LEN_MAX) lenClamp = LEN_MAX;
    else                       lenClamp = bitLen;
  end

  // Last pulse of the current segment and the segment that follows it.
  always_comb begin
    lastPulse = 1'b0;
    nextSeg   = S_IDLE;
    unique case (state)
      S_BOOT:  begin lastPulse = (cnt == BOOT_LAST); nextSeg = S_IDLE; end
      S_HEAD:  begin
        lastPulse = isIr ? (cnt == IR_HEAD_LAST) : (cnt == DR_HEAD_LAST);
        nextSeg   = S_SHIFT;
      end
      S_SHIFT: begin lastPulse = (cnt == lenReg - ONE); nextSeg = S_TAIL; end
      S_TAIL:  begin lastPulse = (cnt == ONE); nextSeg = S_IDLE; end
      S_WAIT:  begin lastPulse = (cnt == waitReg - ONE); nextSeg = S_IDLE; end
      default: begin lastPulse = 1'b0; nextSeg = S_IDLE; end
    endcase
  end

  always_comb begin
    st         = '0;
    st.run     = (state == S_BOOT) || (state == S_HEAD) || (state == S_SHIFT) ||
                 (state == S_TAIL) || ((state == S_WAIT) && (waitReg != '0));
    st.load    = (state == S_IDLE) && start;
    st.shiftEn = (state == S_SHIFT);
    st.capEn   = (state == S_SHIFT) && !isIr;
    st.cmpEn   = (cmdReg == CMD_DRCMP);
    st.bitIdx  = cnt[IDX_W-1:0];
    st.finish  = ((state == S_TAIL) && pulseEnd && lastPulse) ||
                 ((state == S_WAIT) && ((waitReg == '0) || (pulseEnd && lastPulse)));
    unique case (state)
      S_BOOT:  st.tmsBit = (cnt != BOOT_LAST);
      S_HEAD:  st.tmsBit = isIr ? (cnt < CNT_W'(2)) : (cnt == '0);
      S_SHIFT: st.tmsBit = (cnt == lenReg - ONE);
      S_TAIL:  st.tmsBit = (cnt == '0);
      default: st.tmsBit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_BOOT;
      cnt     <= '0;
      cmdReg  <= CMD_IR;
      lenReg  <= '0;
      waitReg <= '0;
      done    <= 1'b0;
    end else begin
      done <= st.finish;
      if (state == S_IDLE) begin
        if (start) begin
          cmdReg  <= cmd_e'(cmd);
          lenReg  <= CNT_W'(lenClamp);
          waitReg <= CNT_W'(waitCnt);
          cnt     <= '0;
          state   <= (cmd_e'(cmd) == CMD_WAIT) ? S_WAIT : S_HEAD;
        end
      end else if (st.finish) begin
        state <= S_IDLE;
        cnt   <= '0;
      end else if (pulseEnd) begin
        if (lastPulse) begin
          cnt   <= '0;
          state <= nextSeg;
        end else begin
          cnt <= cnt + ONE;
        end
      end
    end
  end

endmodule

// File: rtl/jscan_dpath.sv
module jscan_dpath
  import jscan_pkg::*;
#(
  parameter int HALF_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              tdo,
  input  logic [DATA_W-1:0] shiftIn,
  input  logic [DATA_W-1:0] expectIn,
  output logic              pulseEnd,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic [DATA_W-1:0] captureOut,
  output logic              mismatch
);

  localparam int PH_W = (2 * HALF_CYC > 2) ? $clog2(2 * HALF_CYC) : 1;
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF_CYC - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * HALF_CYC - 1);

  logic [PH_W-1:0]   phase;
  logic              riseNow, pulseStart;
  logic [DATA_W-1:0] shReg, expReg, validMask;

  assign pulseEnd   = st.run && (phase == PH_LAST);
  assign riseNow    = st.run && (phase == PH_RISE);
  assign pulseStart = st.run && (phase == '0);

  // TCK divider: low for phases 0..HALF_CYC-1, high for the rest.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      tck   <= 1'b0;
    end else if (!st.run) begin
      phase <= '0;
      tck   <= 1'b0;
    end else begin
      phase <= pulseEnd ? '0 : phase + PH_W'(1);
      if (riseNow)       tck <= 1'b1;
      else if (pulseEnd) tck <= 1'b0;
    end
  end

  // Pin drive: TMS/TDI settle early in the low phase.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tms <= 1'b0;
      tdi <= 1'b0;
    end else if (pulseStart) begin
      tms <= st.tmsBit;
      tdi <= st.shiftEn ? shReg[st.bitIdx] : 1'b0;
    end
  end

  // Operands, capture buffer and compare result.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg      <= '0;
      expReg     <= '0;
      captureOut <= '0;
      validMask  <= '0;
      mismatch   <= 1'b0;
    end else if (st.load) begin
      shReg      <= shiftIn;
      expReg     <= expectIn;
      captureOut <= '0;
      validMask  <= '0;
      mismatch   <= 1'b0;
    end else begin
      if (riseNow && st.capEn) begin
        captureOut[st.bitIdx] <= tdo;
        validMask[st.bitIdx]  <= 1'b1;
      end
      if (st.finish && st.cmpEn)
        mismatch <= |((captureOut ^ expReg) & validMask);
    end
  end

endmodule

// File: rtl/jscan_seq.sv
module jscan_seq
  import jscan_pkg::*;
#(
  parameter int HALF_CYC = 3,
  parameter int LEN_W    = 16,
  parameter int WAIT_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        cmd,
  input  logic [LEN_W-1:0]  bitLen,
  input  logic [WAIT_W-1:0] waitCnt,
  input  logic [DATA_W-1:0] shiftIn,
  input  logic [DATA_W-1:0] expectIn,
  input  logic              tdo,
  output logic              busy,
  output logic              done,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic [DATA_W-1:0] captureOut,
  output logic              mismatch
);

  strobe_t stb;
  logic    pulseEnd;

  jscan_ctrl #(.LEN_W(LEN_W), .WAIT_W(WAIT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cmd      (cmd),
    .bitLen   (bitLen),
    .waitCnt  (waitCnt),
    .pulseEnd (pulseEnd),
    .st       (stb),
    .busy     (busy),
    .done     (done)
  );

  jscan_dpath #(.HALF_CYC(HALF_CYC)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .st         (stb),
    .tdo        (tdo),
    .shiftIn    (shiftIn),
    .expectIn   (expectIn),
    .pulseEnd   (pulseEnd),
    .tck        (tck),
    .tms        (tms),
    .tdi        (tdi),
    .captureOut (captureOut),
    .mismatch   (mismatch)
  );

endmodule

// File: rtl/jscan_seq_chk.sv
module jscan_seq_chk #(
  parameter int HALF_CYC = 3
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic tck,
  input logic tms,
  input logic tdi,
  input logic mismatch
);

  logic [15:0] hiCnt, loCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt <= '0;
      loCnt <= '0;
    end else begin
      hiCnt <= tck ? ((hiCnt == 16'hFFFF) ? hiCnt : hiCnt + 16'd1) : 16'd0;
      loCnt <= !tck ? ((loCnt == 16'hFFFF) ? loCnt : loCnt + 16'd1) : 16'd0;
    end
  end

  // R8: pins hold steady through the high phase
  a_r8_pins_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));

  // R8: high phase has the programmed width
  a_r8_high_width: assert property (@(posedge clk) disable iff (!rstN)
    (!tck && $past(tck)) |-> (hiCnt == 16'(HALF_CYC)));

  // R8: low phase is never shorter than programmed
  a_r8_low_width: assert property (@(posedge clk) disable iff (!rstN)
    (tck && !$past(tck)) |-> (loCnt >= 16'(HALF_CYC)));

  // R4: chain parked with TCK and TMS low whenever idle
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!tck && !tms));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: done appears with busy low
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9: an accepted start makes the engine busy
  a_r9_accept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R6: mismatch only rises together with completion
  a_r6_mismatch_at_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mismatch) |-> done);

endmodule

bind jscan_seq jscan_seq_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .tck      (tck),
  .tms      (tms),
  .tdi      (tdi),
  .mismatch (mismatch)
);

// File: tb/jscan_seq_bench.sv
module jscan_seq_bench;

  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic [15:0] bitLen = 16'd0;
  logic [15:0] waitCnt = 16'd0;
  logic [63:0] shiftIn = 64'd0;
  logic [63:0] expectIn = 64'd0;
  logic        tdo = 1'b0;
  logic        busy, done, tck, tms, tdi, mismatch;
  logic [63:0] captureOut;

  always #10 clk = ~clk;

  jscan_seq #(.HALF_CYC(HALF)) u_jscan_seq (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .bitLen(bitLen),
    .waitCnt(waitCnt), .shiftIn(shiftIn), .expectIn(expectIn), .tdo(tdo),
    .busy(busy), .done(done), .tck(tck), .tms(tms), .tdi(tdi),
    .captureOut(captureOut), .mismatch(mismatch)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- port-level TAP model of the chain ----------------
  // States: 0 TLR,1 RTI,2 SelDR,3 CapDR,4 ShDR,5 Ex1DR,6 PauDR,7 Ex2DR,
  // 8 UpdDR,9 SelIR,10 CapIR,11 ShIR,12 Ex1IR,13 PauIR,14 Ex2IR,15 UpdIR
  function automatic int tapNext(input int s, input logic m);
    case (s)
      0:  return m ? 0 : 1;
      1:  return m ? 2 : 1;
      2:  return m ? 9 : 3;
      3:  return m ? 5 : 4;
      4:  return m ? 5 : 4;
      5:  return m ? 8 : 6;
      6:  return m ? 7 : 6;
      7:  return m ? 8 : 4;
      8:  return m ? 2 : 1;
      9:  return m ? 0 : 10;
      10: return m ? 12 : 11;
      11: return m ? 12 : 11;
      12: return m ? 15 : 13;
      13: return m ? 14 : 13;
      14: return m ? 15 : 11;
      15: return m ? 2 : 1;
      default: return 0;
    endcase
  endfunction

  int          tapSt = 6;
  bit          sawTlr = 1'b0;
  logic [63:0] tdoPat = 64'd0;
  int          tdoIdx = 0;
  int          rises = 0;
  int          irBits = 0;
  int          drBits = 0;
  logic [63:0] inLog = 64'd0;

  always @(posedge tck) begin
    rises++;
    if (tapSt == 4) begin
      if (drBits < 64) inLog[drBits] = tdi;
      drBits++;
    end else if (tapSt == 11) begin
      if (irBits < 64) inLog[irBits] = tdi;
      irBits++;
    end
    tapSt = tapNext(tapSt, tms);
    if (tapSt == 0) sawTlr = 1'b1;
    if (tapSt == 3) tdoIdx = 0;
  end

  always @(negedge tck) begin
    if (tapSt == 4) begin
      tdo = (tdoIdx < 64) ? tdoPat[tdoIdx] : 1'b0;
      tdoIdx++;
    end
  end

  // ---------------- TCK phase width measurement (R8) ----------------
  int hiRun = 0, loRun = 0;
  int minHi = 9999, maxHi = 0, minLo = 9999;
  always @(negedge clk) begin
    if (tck) begin
      if (loRun > 0 && loRun < minLo) minLo = loRun;
      loRun = 0;
      hiRun++;
    end else begin
      if (hiRun > 0) begin
        if (hiRun < minHi) minHi = hiRun;
        if (hiRun > maxHi) maxHi = hiRun;
      end
      hiRun = 0;
      loRun++;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    int          kind;
    int          len;
    logic [63:0] shiftV;
    logic [63:0] cap;
    logic        mis;
    int          nRise;
  } exp_t;

  exp_t sbq[$];
  exp_t cur;

  function automatic logic [63:0] lenMask(input int n);
    return (n >= 64) ? {64{1'b1}} : ((64'd1 << n) - 64'd1);
  endfunction

  always @(negedge clk) begin
    if (rstN && done) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R9 done without accepted command", 1, 0);
      end else begin
        cur = sbq.pop_front();
        check(busy == 1'b0, "R9 busy low at done", busy, 0);
        check(captureOut == cur.cap, "R5 captured TDO word", captureOut, cur.cap);
        check(mismatch == cur.mis, "R6 compare result", mismatch, cur.mis);
        check(tapSt == 1, "R4 chain back in Run-Test/Idle", tapSt, 1);
        if (cur.kind == 3) begin
          check(rises == cur.nRise, "R7 wait pulse count", rises, cur.nRise);
          check(irBits == 0 && drBits == 0, "R7 wait shifts nothing", irBits + drBits, 0);
        end else begin
          check(rises == cur.nRise, "R2 pulse count of scan", rises, cur.nRise);
          if (cur.kind == 0)
            check(irBits == cur.len && drBits == 0, "R2 IR path bit count", irBits, cur.len);
          else
            check(drBits == cur.len && irBits == 0, "R2 DR path bit count", drBits, cur.len);
          check((inLog & lenMask(cur.len)) == (cur.shiftV & lenMask(cur.len)),
                "R3 TDI bits LSB first", inLog, cur.shiftV & lenMask(cur.len));
        end
      end
    end
  end

  // driver: compute expectation, push, pulse start
  task automatic issue(input int c, input int len, input logic [63:0] sh,
                       input logic [63:0] ex, input int w, input logic [63:0] pat);
    exp_t e;
    int   effLen;
    effLen   = (len == 0) ? 1 : ((len > 64) ? 64 : len);
    e.kind   = c;
    e.len    = effLen;
    e.shiftV = sh;
    e.cap    = (c == 1 || c == 2) ? (pat & lenMask(effLen)) : 64'd0;
    e.mis    = (c == 2) && (|((pat ^ ex) & lenMask(effLen)));
    e.nRise  = (c == 0) ? 6 + effLen : ((c == 3) ? w : 5 + effLen);
    sbq.push_back(e);
    rises  = 0;
    irBits = 0;
    drBits = 0;
    inLog  = 64'd0;
    tdoPat = pat;
    @(negedge clk);
    cmd      = c[1:0];
    bitLen   = len[15:0];
    waitCnt  = w[15:0];
    shiftIn  = sh;
    expectIn = ex;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input int c, input int len, input logic [63:0] sh,
                     input logic [63:0] ex, input int w, input logic [63:0] pat);
    issue(c, len, sh, ex, w, pat);
    drain();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: boot sequence runs on its own
    check(busy == 1'b1, "R1 busy during boot", busy, 1);
    check(captureOut == 64'd0 && mismatch == 1'b0, "R5 reset state of results",
          captureOut, 0);
    while (busy) @(negedge clk);
    check(rises == 6, "R1 boot pulse count", rises, 6);
    check(sawTlr, "R1 passes through Test-Logic-Reset", sawTlr, 1);
    check(tapSt == 1, "R1 boot ends in Run-Test/Idle", tapSt, 1);
    repeat (3) @(negedge clk);

    // R2 R3: instruction scan, 5 bits
    run(0, 5, 64'h15, 64'd0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    // R5: data scan, 8 bits
    run(1, 8, 64'hA5, 64'd0, 0, 64'h3C);
    // R6: full-width compare, matching
    run(2, 64, 64'hDEAD_BEEF_0123_4567, 64'h8421_F00D_5A5A_C3C3, 0,
        64'h8421_F00D_5A5A_C3C3);
    // R6: compare with a difference at bit 7
    run(2, 16, 64'h1234, 64'h00F0, 0, 64'h0070);
    // R6 R5: difference only above the length is ignored, and the flag clears
    run(2, 12, 64'h0ABC, 64'h0010_0ABC, 0, 64'h0000_0ABC);
    // R3: zero length acts as one bit
    run(1, 0, 64'h1, 64'd0, 0, 64'h1);
    // R3: overlong instruction scan clamps to 64 bits
    run(0, 100, 64'hF0F0_1234_8765_0F0F, 64'd0, 0, 64'd0);
    // R7: wait of 10 periods, then of 0
    run(3, 0, 64'd0, 64'd0, 10, 64'd0);
    run(3, 0, 64'd0, 64'd0, 0, 64'd0);

    // R9: a start while busy is ignored
    issue(1, 8, 64'h5A, 64'd0, 0, 64'hC3);
    repeat (20) @(negedge clk);
    cmd     = 2'd3;
    waitCnt = 16'd5;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (40) @(negedge clk);
    check(rises == 13, "R9 start while busy ignored (pulse count)", rises, 13);
    check(busy == 1'b0, "R9 engine idle after ignored start", busy, 0);

    // R8: TCK phase widths
    check(minHi == HALF && maxHi == HALF, "R8 TCK high width", minHi, HALF);
    check(minLo == HALF, "R8 TCK low width", minLo, HALF);

    summary();
    $finish;
  end

endmodule